// File: doc/BRIEF.md
# Ultra-DMA Operation Control and Status Unit

This unit is the register-side front end of an Ultra-DMA engine on a parallel ATA port. Software programs a direction and an enable bit in an operation register. The enable is honoured only after a fixed arming sequence. Once the engine runs, a system DMA channel moves 32-bit words through two data ports: a write-only port for host-to-device traffic and a read-only port for device-to-host traffic. A two-entry word buffer sits between those ports and the ATA side. The ATA-side burst signalling is reduced to a single word strobe. Each strobe that the unit can serve moves one word and adds one to a transfer counter.

The arming controller has four states. IDLE is the reset state, and nothing runs there. DIR_SET is entered when the operation register is written with the enable clear; that write latches the direction. RD_SEEN is entered from DIR_SET when the operation register is read. BUSY is entered from RD_SEEN when the register is written with the enable set and the same direction. The other named transitions are these. A write with the enable clear re-enters DIR_SET from IDLE, DIR_SET or RD_SEEN, and it relatches the direction. In BUSY, a write with the enable clear is a stop and goes to IDLE. Every other enable write is ignored.

When the engine is stopped, the unit looks at the word count. It records an incomplete-transfer flag for the active direction and a flag for a length that is not a multiple of four words. Any recorded flag drives an error-interrupt bit. The flags stay set until the next arming sequence completes.

Top module: `udma_ctl_unit`

## Requirements
- R1: After reset, the operation register (offset 0x0C) reads 0, the status register (offset 0x28) reads 0, and `dma_req` is low.
- R2: The operation register has the enable at bit 0 and the direction at bit 1, where 1 means host-to-device. The engine becomes busy, shown by status bit 18 and operation bit 0, after three steps. First the direction is written with the enable clear. Then the operation register is read. Then the same direction is written with the enable set.
- R3: An enable write that has not been preceded by a read of the operation register since the last direction write is ignored, and the engine stays not busy. This applies in IDLE and in DIR_SET.
- R4: An enable write whose direction differs from the latched direction is ignored. The unit stays in RD_SEEN, so a matching enable write can still arm it afterwards.
- R5: A write to the operation register with the enable clear while busy stops the engine. Status bit 18 and `dma_req` then read 0.
- R6: While the engine is busy, `dma_req` and status bit 16 are high under these conditions. In host-to-device mode they are high when the word buffer is not full. In device-to-host mode they are high when the buffer holds a word. They are low whenever the engine is not busy.
- R7: In host-to-device mode, words written to offset 0x20 appear on `ata_dout` in write order. Each served `ata_strobe` consumes one word.
- R8: In device-to-host mode, each served `ata_strobe` captures `ata_din`. Reads of offset 0x24 return the captured words in order.
- R9: A stop with a non-zero word count sets status bit 24 in host-to-device mode or status bit 25 in device-to-host mode. The stop sets bit 26 when the count modulo 4 is non-zero. Bit 17 is the OR of bits 24 to 26.
- R10: The error flags and bit 17 are cleared when the next arming sequence completes, and the word count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| dma_req | output | 1 | Request toward the system DMA channel |
| ata_strobe | input | 1 | ATA-side word strobe |
| ata_din | input | 32 | Word from the device, device-to-host |
| ata_dout | output | 32 | Word to the device, host-to-device |
| ata_word_ok | output | 1 | A strobe in this cycle would be served |

## Verification
Read data is combinational, so a read result is due in the same cycle as the read strobe. The bench samples it one time step after driving the strobe at a falling edge. State changes, status bits, `dma_req` and flag updates are due one rising edge after the write or strobe that causes them. The bench therefore checks them on a later access, after that edge has passed. A stop records the count of words served before the stop edge, so the bench compares the status after the stop against the number of strobes it issued.

// File: rtl/udma_pkg.sv
package udma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIR_SET = 2'd1,
        ST_RD_SEEN = 2'd2,
        ST_BUSY    = 2'd3
    } arm_state_e;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_OP   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_DOUT = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_DIN  = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h28;

    localparam int unsigned OP_EN_BIT  = 0;
    localparam int unsigned OP_DIR_BIT = 1;

    localparam int unsigned STAT_DREQ_BIT = 16;
    localparam int unsigned STAT_INT_BIT  = 17;
    localparam int unsigned STAT_BUSY_BIT = 18;
    localparam int unsigned STAT_NDO_BIT  = 24;
    localparam int unsigned STAT_NDI_BIT  = 25;
    localparam int unsigned STAT_N4X_BIT  = 26;

endpackage

// File: rtl/udma_arm_fsm.sv
module udma_arm_fsm
    import udma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_wr,
    input  logic op_rd,
    input  logic wr_en,
    input  logic wr_dir,
    output logic busy,
    output logic dir,
    output logic arm_go,
    output logic stop_go
);

    arm_state_e state_q, state_d;
    logic       dir_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (op_wr && !wr_en && state_q != ST_BUSY)
                dir_q <= wr_dir;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_wr && !wr_en)
                    state_d = ST_DIR_SET;
            end
            ST_DIR_SET: begin
                if (op_wr && !wr_en)
                    state_d = ST_DIR_SET;
                else if (op_rd)
                    state_d = ST_RD_SEEN;
            end
            ST_RD_SEEN: begin
                if (op_wr && !wr_en)
                    state_d = ST_DIR_SET;
                else if (op_wr && wr_en && wr_dir == dir_q)
                    state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (op_wr && !wr_en)
                    state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_BUSY);
        dir     = dir_q;
        arm_go  = (state_q == ST_RD_SEEN) && op_wr && wr_en && (wr_dir == dir_q);
        stop_go = (state_q == ST_BUSY) && op_wr && !wr_en;
    end

    // R2: busy is only ever entered from RD_SEEN
    p_arm_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && $past(state_q) != ST_BUSY) |-> $past(state_q) == ST_RD_SEEN);

    // R3: enable write in DIR_SET does not advance
    p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIR_SET && op_wr && wr_en) |=> state_q == ST_DIR_SET);

    // R5: enable-clear write while busy returns to idle
    p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_wr && !wr_en) |=> state_q == ST_IDLE);

endmodule

// File: rtl/udma_word_buf.sv
module udma_word_buf #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DEPTH);

    logic [WIDTH-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [FILL_W-1:0] fill_q;
    logic              do_push, do_pop;

    assign full    = (fill_q == FILL_FULL);
    assign empty   = (fill_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (do_push)
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)
                fill_q <= fill_q + 1'b1;
            else if (do_pop && !do_push)
                fill_q <= fill_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (do_push && !flush && wr_ptr_q == PTR_W'(g))
                mem_q[g] <= push_data;
        end
    end

    // R6: the buffer never holds more than DEPTH words
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_FULL);

    // R7: a push into a full buffer without a pop leaves the fill unchanged
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/udma_err_track.sv
module udma_err_track #(
    parameter int unsigned CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic word_tick,
    input  logic stop_go,
    input  logic dir,
    output logic ndo,
    output logic ndi,
    output logic n4x,
    output logic err_int
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ndo_q, ndi_q, n4x_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ndo_q <= 1'b0;
            ndi_q <= 1'b0;
            n4x_q <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            ndo_q <= 1'b0;
            ndi_q <= 1'b0;
            n4x_q <= 1'b0;
        end else begin
            if (word_tick && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (stop_go) begin
                if (cnt_q != '0) begin
                    if (dir) ndo_q <= 1'b1;
                    else     ndi_q <= 1'b1;
                end
                if (cnt_q[1:0] != 2'b00)
                    n4x_q <= 1'b1;
            end
        end
    end

    assign ndo     = ndo_q;
    assign ndi     = ndi_q;
    assign n4x     = n4x_q;
    assign err_int = ndo_q | ndi_q | n4x_q;

    // R10: completing an arming sequence clears every flag
    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !(ndo || ndi || n4x));

    // R9: flags only change on a stop or a clear
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !stop_go) |=> $stable({ndo_q, ndi_q, n4x_q}));

endmodule

// File: rtl/udma_ctl_unit.sv
module udma_ctl_unit
    import udma_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_DEPTH = 2,
    parameter int unsigned MAX_BYTES = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 dma_req,
    input  logic                 ata_strobe,
    input  logic [DATA_W-1:0]    ata_din,
    output logic [DATA_W-1:0]    ata_dout,
    output logic                 ata_word_ok
);

    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned CNT_W      = $clog2(MAX_BYTES / WORD_BYTES);

    logic op_wr, op_rd, dout_wr, din_rd;
    logic busy, dir, arm_go, stop_go;
    logic buf_full, buf_empty, buf_push, buf_pop, buf_flush;
    logic [DATA_W-1:0] buf_head, buf_wdata;
    logic word_tick;
    logic ndo, ndi, n4x, err_int;

    assign op_wr   = reg_wr && reg_addr == OFF_OP;
    assign op_rd   = reg_rd && reg_addr == OFF_OP;
    assign dout_wr = reg_wr && reg_addr == OFF_DOUT && busy && dir;
    assign din_rd  = reg_rd && reg_addr == OFF_DIN && busy && !dir;

    udma_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_wr   (op_wr),
        .op_rd   (op_rd),
        .wr_en   (reg_wdata[OP_EN_BIT]),
        .wr_dir  (reg_wdata[OP_DIR_BIT]),
        .busy    (busy),
        .dir     (dir),
        .arm_go  (arm_go),
        .stop_go (stop_go)
    );

    assign ata_word_ok = busy && (dir ? !buf_empty : !buf_full);
    assign word_tick   = ata_strobe && ata_word_ok;
    assign buf_push    = dir ? dout_wr : word_tick;
    assign buf_pop     = dir ? word_tick : din_rd;
    assign buf_wdata   = dir ? reg_wdata : ata_din;
    assign buf_flush   = arm_go || stop_go;

    udma_word_buf #(
        .WIDTH (DATA_W),
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (buf_flush),
        .push      (buf_push),
        .push_data (buf_wdata),
        .pop       (buf_pop),
        .head      (buf_head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    udma_err_track #(
        .CNT_W (CNT_W)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm_go),
        .word_tick (word_tick),
        .stop_go   (stop_go),
        .dir       (dir),
        .ndo       (ndo),
        .ndi       (ndi),
        .n4x       (n4x),
        .err_int   (err_int)
    );

    assign dma_req  = busy && (dir ? !buf_full : !buf_empty);
    assign ata_dout = buf_head;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_OP: begin
                reg_rdata[OP_EN_BIT]  = busy;
                reg_rdata[OP_DIR_BIT] = dir;
            end
            OFF_STAT: begin
                reg_rdata[STAT_DREQ_BIT] = dma_req;
                reg_rdata[STAT_INT_BIT]  = err_int;
                reg_rdata[STAT_BUSY_BIT] = busy;
                reg_rdata[STAT_NDO_BIT]  = ndo;
                reg_rdata[STAT_NDI_BIT]  = ndi;
                reg_rdata[STAT_N4X_BIT]  = n4x;
            end
            OFF_DIN: reg_rdata = dir ? '0 : buf_head;
            default: reg_rdata = '0;
        endcase
    end

    // R6: no DMA request while the engine is not running
    p_dreq_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> busy);

    // R5: after a stop the request is withdrawn
    p_stop_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_go |=> !dma_req);

    // R2: the engine is busy one cycle after an arming write
    p_arm_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_go |=> busy);

endmodule

// File: tb/udma_ctl_unit_tb.sv
module udma_ctl_unit_tb;

    localparam logic [5:0] A_OP   = 6'h0C;
    localparam logic [5:0] A_DOUT = 6'h20;
    localparam logic [5:0] A_DIN  = 6'h24;
    localparam logic [5:0] A_STAT = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_req;
    logic        ata_strobe = 1'b0;
    logic [31:0] ata_din = '0;
    logic [31:0] ata_dout;
    logic        ata_word_ok;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    udma_ctl_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .dma_req     (dma_req),
        .ata_strobe  (ata_strobe),
        .ata_din     (ata_din),
        .ata_dout    (ata_dout),
        .ata_word_ok (ata_word_ok)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic strobe(input logic [31:0] din, output logic [31:0] dout);
        @(negedge clk);
        ata_strobe = 1'b1; ata_din = din;
        #1 dout = ata_dout;
        @(negedge clk);
        ata_strobe = 1'b0;
    endtask

    task automatic arm(input logic d);
        logic [31:0] tmp;
        wr(A_OP, {30'd0, d, 1'b0});
        rd(A_OP, tmp);
        wr(A_OP, {30'd0, d, 1'b1});
    endtask

    // status word from the requirement bit positions (R6, R9, R2)
    function automatic logic [31:0] exp_stat(input logic busy, input logic dreq,
                                             input logic d, input int n_words, input logic stopped);
        logic [31:0] s = '0;
        s[18] = busy;
        s[16] = dreq;
        if (stopped) begin
            if (n_words != 0) begin
                if (d) s[24] = 1'b1;
                else   s[25] = 1'b1;
            end
            if ((n_words % 4) != 0) s[26] = 1'b1;
            s[17] = s[24] | s[25] | s[26];
        end
        return s;
    endfunction

    task automatic run_xfer(input logic d, input int n);
        logic [31:0] v, w, got;
        arm(d);
        rd(A_STAT, got);
        check("R10 flags cleared on arm", got, exp_stat(1'b1, d, d, 0, 1'b0));
        for (int i = 0; i < n; i++) begin
            w = $urandom();
            if (d) begin
                wr(A_DOUT, w);
                strobe(32'h0, v);
                check("R7 data-out order", v, w);
            end else begin
                strobe(w, v);
                rd(A_DIN, got);
                check("R8 data-in order", got, w);
            end
        end
        wr(A_OP, 32'h0);
        rd(A_STAT, got);
        check("R9 stop flags", got, exp_stat(1'b0, 1'b0, d, n, 1'b1));
    endtask

    initial begin
        logic [31:0] r, v;
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_OP, r);   check("R1 op reset", r, 32'h0);
        rd(A_STAT, r); check("R1 status reset", r, 32'h0);
        check("R1 dma_req reset", {31'd0, dma_req}, 32'h0);

        // R3 enable in IDLE ignored
        wr(A_OP, 32'h1);
        rd(A_STAT, r); check("R3 enable in idle ignored", r, 32'h0);
        // R3 enable in DIR_SET without read ignored
        wr(A_OP, 32'h2);
        wr(A_OP, 32'h3);
        rd(A_STAT, r); check("R3 enable without read ignored", r, 32'h0);

        // R4 mismatched direction ignored, then matching arms
        rd(A_OP, r);   check("R2 op readback dir", r, 32'h2);
        wr(A_OP, 32'h1);
        rd(A_STAT, r); check("R4 mismatched dir ignored", r, 32'h0);
        wr(A_OP, 32'h3);
        rd(A_OP, r);   check("R2 op busy readback", r, 32'h3);
        rd(A_STAT, r); check("R2 busy after arming", r, exp_stat(1'b1, 1'b1, 1'b1, 0, 1'b0));

        // R6 host-to-device request follows buffer room
        check("R6 dreq empty out", {31'd0, dma_req}, 32'h1);
        wr(A_DOUT, 32'hA5A5_0001);
        wr(A_DOUT, 32'hA5A5_0002);
        check("R6 dreq full out", {31'd0, dma_req}, 32'h0);
        wr(A_DOUT, 32'hDEAD_BEEF);
        strobe(32'h0, v); check("R7 first word", v, 32'hA5A5_0001);
        check("R6 dreq room again", {31'd0, dma_req}, 32'h1);
        strobe(32'h0, v); check("R7 second word, overflow dropped", v, 32'hA5A5_0002);
        strobe(32'h0, v);
        check("R7 empty buffer not served", {31'd0, ata_word_ok}, 32'h0);

        // R5 stop with count 2: out-incomplete and not-multiple-of-4
        wr(A_OP, 32'h0);
        rd(A_STAT, r); check("R5 R9 stop after 2 words", r, exp_stat(1'b0, 1'b0, 1'b1, 2, 1'b1));
        check("R5 dreq low after stop", {31'd0, dma_req}, 32'h0);

        // R6 device-to-host request follows buffer content
        arm(1'b0);
        check("R6 dreq empty in", {31'd0, dma_req}, 32'h0);
        strobe(32'h1234_5678, v);
        check("R6 dreq word held", {31'd0, dma_req}, 32'h1);
        rd(A_DIN, r); check("R8 captured word", r, 32'h1234_5678);
        check("R6 dreq drained", {31'd0, dma_req}, 32'h0);
        wr(A_OP, 32'h0);
        rd(A_STAT, r); check("R9 stop after 1 in word", r, exp_stat(1'b0, 1'b0, 1'b0, 1, 1'b1));

        // directed corners: zero words and exactly four words
        run_xfer(1'b1, 0);
        run_xfer(1'b0, 4);
        run_xfer(1'b1, 8);

        // random transfers
        for (int k = 0; k < 10; k++)
            run_xfer(1'($urandom_range(0, 1)), int'($urandom_range(0, 11)));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule